// File: doc/BRIEF.md
# Writeback Slot Allocator Queue

This block sits between the execution units and the commit side of an out-of-order core. It gives finished instructions a place in a writeback buffer that spans several future cycles. Each cycle has a fixed number of slots. When an execution unit finishes, it raises a request. The allocator then scans the buffer for the first free slot and stores the instruction's record there: its thread, squash and executed flags, and up to two destination tags.

The buffer moves forward by one row every cycle. The head row is handed to the commit side. Each head entry that was executed and not squashed raises a scoreboard set strobe and a dependent-wakeup strobe for each valid destination tag. Squashed entries are still delivered and counted, so the slots they held can be released. If no free slot exists within capacity, the request is dropped and an overflow flag is raised.

Top module: `wb_slot_alloc`

## Requirements
- R1: In the first cycle after reset, no head slot is delivered, no set or wakeup strobe is raised, the release count is 0 and overflow is low.
- R2: The capacity is WB_WIDTH*WB_DEPTH positions, numbered p = c*WB_WIDTH + s (row offset c, slot s). An entry granted position p in a cycle appears on head slot s exactly c+1 cycles later. It appears there with its thread id and squashed flag.
- R3: Requests are served in ascending request index. Each request takes the lowest free position, and the search restarts at position 0 in every cycle. `grant_pos` field k reports the position given to request k.
- R4: A valid request that finds no free position below capacity is not granted. `ovf` is high in that cycle, and the entry is never delivered.
- R5: Head delivery takes slots in order from slot 0 and stops at the first empty slot. `cmt_vld` is always a contiguous run starting at bit 0.
- R6: Bit i*2+j of `sb_set_vld` and of `wake_vld` is high only when all of these hold: head slot i is delivered, it was executed, it is not squashed, and its destination j is valid. The matching tag field of `sb_set_tag` and of `wake_tag` carries that destination tag.
- R7: Entries that are squashed or not executed are still delivered on `cmt_vld`, with `cmt_squash` showing the squashed flag.
- R8: `rel_cnt` equals the number of head slots delivered in that cycle, squashed ones included.
- R9: A request whose valid bit is low is ignored. It gets no grant, it takes no position, and nothing is later delivered for it, whatever its other fields hold.
- R10: Every cycle the buffer advances by one row. The row that enters at the far end is empty, so positions (WB_DEPTH-1)*WB_WIDTH and above are free to the requests of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NREQ | Request valid, one bit per execution port |
| req_exec | input | NREQ | Instruction has executed |
| req_squash | input | NREQ | Instruction is squashed |
| req_tid | input | NREQ*2 | Thread id per request |
| req_dst_vld | input | NREQ*2 | Destination valid, two per request |
| req_dst_tag | input | NREQ*12 | Destination tags, 6 bits each, two per request |
| grant_vld | output | NREQ | Request placed this cycle |
| grant_pos | output | NREQ*POS_W | Linear position given to each request |
| ovf | output | 1 | A valid request found no free slot |
| cmt_vld | output | WB_WIDTH | Head slot delivered to commit |
| cmt_squash | output | WB_WIDTH | Delivered entry was squashed |
| cmt_tid | output | WB_WIDTH*2 | Thread id of each delivered entry |
| rel_cnt | output | CNT_W | Number of entries delivered this cycle |
| sb_set_vld | output | WB_WIDTH*2 | Register-ready strobe per head destination |
| sb_set_tag | output | WB_WIDTH*12 | Register-ready tags |
| wake_vld | output | WB_WIDTH*2 | Dependent-wakeup strobe per head destination |
| wake_tag | output | WB_WIDTH*12 | Wakeup tags |

## Verification
The bound checker tests every cycle the properties that hold at any instant:
- the head delivery forms a contiguous run;
- strobes appear only for delivered, unsquashed slots, and wakeup mirrors scoreboard set;
- the release count matches the delivered slots;
- idle requests are never granted, and overflow always comes with a missing grant;
- position 0 always reaches the head one cycle after it is granted.

Only the bench scenarios can show the rest. The exact first-free placement across rows, the delay of c+1 cycles for deeper positions, and the loss of dropped entries once the buffer fills all need a reference model of the buffer's contents.

// File: rtl/wbq_pkg.sv
`timescale 1ns/1ps
package wbq_pkg;

    // Record widths shared by every slot of the buffer
    parameter int unsigned SLOT_TID_W = 2;
    parameter int unsigned SLOT_TAG_W = 6;
    parameter int unsigned SLOT_NDST  = 2;

    typedef struct packed {
        logic                                   vld;
        logic                                   squash;
        logic                                   exec;
        logic [SLOT_TID_W-1:0]                  tid;
        logic [SLOT_NDST-1:0]                   dvld;
        logic [SLOT_NDST-1:0][SLOT_TAG_W-1:0]   dtag;
    } slot_t;

    // Linear position of row offset c, slot s
    function automatic int unsigned lin_pos(input int unsigned c,
                                            input int unsigned s,
                                            input int unsigned width);
        return c * width + s;
    endfunction

    // A destination is published only for clean, finished work
    function automatic logic dst_publish(input slot_t e, input int unsigned j);
        return e.vld && e.exec && !e.squash && e.dvld[j];
    endfunction

endpackage

// File: rtl/wbq_alloc.sv
`timescale 1ns/1ps
module wbq_alloc
    import wbq_pkg::*;
#(
    parameter int unsigned WB_WIDTH = 2,
    parameter int unsigned WB_DEPTH = 4,
    parameter int unsigned NREQ     = 3,
    localparam int unsigned CAP     = WB_WIDTH * WB_DEPTH,
    localparam int unsigned POS_W   = (CAP > 1) ? $clog2(CAP) : 1
) (
    input  logic [CAP-1:0]              occ,
    input  logic [NREQ-1:0]             req_vld,
    output logic [NREQ-1:0]             gnt,
    output logic [NREQ-1:0][POS_W-1:0]  pos,
    output logic                        ovf
);

    // Requests are served in index order. Each one scans from row offset 0,
    // slot 0, moving to the next slot while it is taken and to the next row
    // once the slot index reaches the width.
    always_comb begin : scan
        logic [CAP-1:0] taken;
        logic           hit;
        taken = occ;
        ovf   = 1'b0;
        for (int k = 0; k < NREQ; k++) begin
            gnt[k] = 1'b0;
            pos[k] = '0;
            hit    = 1'b0;
            if (req_vld[k]) begin
                for (int c = 0; c < WB_DEPTH; c++) begin
                    for (int s = 0; s < WB_WIDTH; s++) begin
                        if (!hit && !taken[lin_pos(c, s, WB_WIDTH)]) begin
                            hit                            = 1'b1;
                            taken[lin_pos(c, s, WB_WIDTH)] = 1'b1;
                            gnt[k]                         = 1'b1;
                            pos[k] = POS_W'(lin_pos(c, s, WB_WIDTH));
                        end
                    end
                end
                if (!hit) begin
                    ovf = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wbq_rows.sv
`timescale 1ns/1ps
module wbq_rows
    import wbq_pkg::*;
#(
    parameter int unsigned WB_WIDTH = 2,
    parameter int unsigned WB_DEPTH = 4,
    parameter int unsigned NREQ     = 3,
    localparam int unsigned CAP     = WB_WIDTH * WB_DEPTH,
    localparam int unsigned POS_W   = (CAP > 1) ? $clog2(CAP) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  slot_t                       wr_ent [NREQ],
    input  logic [NREQ-1:0]             wr_en,
    input  logic [NREQ-1:0][POS_W-1:0]  wr_pos,
    output slot_t                       head [WB_WIDTH],
    output logic [CAP-1:0]              occ_post
);

    slot_t q   [CAP];
    slot_t nxt [CAP];

    // Occupancy as seen after this cycle's advance: the far row is empty
    always_comb begin
        for (int p = 0; p < CAP - WB_WIDTH; p++) begin
            occ_post[p] = q[p + WB_WIDTH].vld;
        end
        for (int p = CAP - WB_WIDTH; p < CAP; p++) begin
            occ_post[p] = 1'b0;
        end
    end

    // Advance by one row, clear the far row, then place granted entries
    always_comb begin
        for (int p = 0; p < CAP - WB_WIDTH; p++) begin
            nxt[p] = q[p + WB_WIDTH];
        end
        for (int p = CAP - WB_WIDTH; p < CAP; p++) begin
            nxt[p] = '0;
        end
        for (int k = 0; k < NREQ; k++) begin
            if (wr_en[k]) begin
                nxt[wr_pos[k]] = wr_ent[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < CAP; p++) begin
                q[p] <= '0;
            end
        end else begin
            q <= nxt;
        end
    end

    for (genvar i = 0; i < WB_WIDTH; i++) begin : g_head
        assign head[i] = q[i];
    end

endmodule

// File: rtl/wbq_drain.sv
`timescale 1ns/1ps
module wbq_drain
    import wbq_pkg::*;
#(
    parameter int unsigned WB_WIDTH = 2,
    localparam int unsigned CNT_W   = $clog2(WB_WIDTH + 1)
) (
    input  slot_t                                  head [WB_WIDTH],
    output logic [WB_WIDTH-1:0]                    cmt_vld,
    output logic [WB_WIDTH-1:0]                    cmt_squash,
    output logic [WB_WIDTH*SLOT_TID_W-1:0]         cmt_tid,
    output logic [CNT_W-1:0]                       rel_cnt,
    output logic [WB_WIDTH*SLOT_NDST-1:0]          sb_set_vld,
    output logic [WB_WIDTH*SLOT_NDST*SLOT_TAG_W-1:0] sb_set_tag,
    output logic [WB_WIDTH*SLOT_NDST-1:0]          wake_vld,
    output logic [WB_WIDTH*SLOT_NDST*SLOT_TAG_W-1:0] wake_tag
);

    logic [WB_WIDTH-1:0] take;

    // Take head slots in order and stop at the first hole
    always_comb begin : walk
        logic run;
        run     = 1'b1;
        rel_cnt = '0;
        for (int i = 0; i < WB_WIDTH; i++) begin
            take[i] = run && head[i].vld;
            run     = take[i];
            rel_cnt = rel_cnt + CNT_W'(take[i]);
        end
    end

    for (genvar i = 0; i < WB_WIDTH; i++) begin : g_slot
        assign cmt_vld[i]    = take[i];
        assign cmt_squash[i] = take[i] && head[i].squash;
        assign cmt_tid[i*SLOT_TID_W +: SLOT_TID_W] =
            take[i] ? head[i].tid : '0;
        for (genvar j = 0; j < SLOT_NDST; j++) begin : g_dst
            localparam int unsigned IDX = i * SLOT_NDST + j;
            logic pub;
            assign pub = take[i] && dst_publish(head[i], j);
            assign sb_set_vld[IDX] = pub;
            assign wake_vld[IDX]   = pub;
            assign sb_set_tag[IDX*SLOT_TAG_W +: SLOT_TAG_W] = head[i].dtag[j];
            assign wake_tag[IDX*SLOT_TAG_W +: SLOT_TAG_W]   = head[i].dtag[j];
        end
    end

endmodule

// File: rtl/wb_slot_alloc.sv
`timescale 1ns/1ps
module wb_slot_alloc
    import wbq_pkg::*;
#(
    parameter int unsigned WB_WIDTH = 2,
    parameter int unsigned WB_DEPTH = 4,
    parameter int unsigned NREQ     = 3,
    localparam int unsigned CAP     = WB_WIDTH * WB_DEPTH,
    localparam int unsigned POS_W   = (CAP > 1) ? $clog2(CAP) : 1,
    localparam int unsigned CNT_W   = $clog2(WB_WIDTH + 1)
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [NREQ-1:0]                           req_vld,
    input  logic [NREQ-1:0]                           req_exec,
    input  logic [NREQ-1:0]                           req_squash,
    input  logic [NREQ*SLOT_TID_W-1:0]                req_tid,
    input  logic [NREQ*SLOT_NDST-1:0]                 req_dst_vld,
    input  logic [NREQ*SLOT_NDST*SLOT_TAG_W-1:0]      req_dst_tag,
    output logic [NREQ-1:0]                           grant_vld,
    output logic [NREQ*POS_W-1:0]                     grant_pos,
    output logic                                      ovf,
    output logic [WB_WIDTH-1:0]                       cmt_vld,
    output logic [WB_WIDTH-1:0]                       cmt_squash,
    output logic [WB_WIDTH*SLOT_TID_W-1:0]            cmt_tid,
    output logic [CNT_W-1:0]                          rel_cnt,
    output logic [WB_WIDTH*SLOT_NDST-1:0]             sb_set_vld,
    output logic [WB_WIDTH*SLOT_NDST*SLOT_TAG_W-1:0]  sb_set_tag,
    output logic [WB_WIDTH*SLOT_NDST-1:0]             wake_vld,
    output logic [WB_WIDTH*SLOT_NDST*SLOT_TAG_W-1:0]  wake_tag
);

    localparam int unsigned DTAG_W = SLOT_NDST * SLOT_TAG_W;

    slot_t                       req_ent [NREQ];
    slot_t                       head    [WB_WIDTH];
    logic [CAP-1:0]              occ_post;
    logic [NREQ-1:0][POS_W-1:0]  pos;

    for (genvar k = 0; k < NREQ; k++) begin : g_req
        assign req_ent[k].vld    = req_vld[k];
        assign req_ent[k].squash = req_squash[k];
        assign req_ent[k].exec   = req_exec[k];
        assign req_ent[k].tid    = req_tid[k*SLOT_TID_W +: SLOT_TID_W];
        assign req_ent[k].dvld   = req_dst_vld[k*SLOT_NDST +: SLOT_NDST];
        assign req_ent[k].dtag   = req_dst_tag[k*DTAG_W +: DTAG_W];
    end

    wbq_alloc #(
        .WB_WIDTH (WB_WIDTH),
        .WB_DEPTH (WB_DEPTH),
        .NREQ     (NREQ)
    ) u_alloc (
        .occ     (occ_post),
        .req_vld (req_vld),
        .gnt     (grant_vld),
        .pos     (pos),
        .ovf     (ovf)
    );

    assign grant_pos = pos;

    wbq_rows #(
        .WB_WIDTH (WB_WIDTH),
        .WB_DEPTH (WB_DEPTH),
        .NREQ     (NREQ)
    ) u_rows (
        .clk      (clk),
        .rst      (rst),
        .wr_ent   (req_ent),
        .wr_en    (grant_vld),
        .wr_pos   (pos),
        .head     (head),
        .occ_post (occ_post)
    );

    wbq_drain #(
        .WB_WIDTH (WB_WIDTH)
    ) u_drain (
        .head       (head),
        .cmt_vld    (cmt_vld),
        .cmt_squash (cmt_squash),
        .cmt_tid    (cmt_tid),
        .rel_cnt    (rel_cnt),
        .sb_set_vld (sb_set_vld),
        .sb_set_tag (sb_set_tag),
        .wake_vld   (wake_vld),
        .wake_tag   (wake_tag)
    );

endmodule

// File: rtl/wbq_chk.sv
`timescale 1ns/1ps
module wbq_chk
    import wbq_pkg::*;
#(
    parameter int unsigned WB_WIDTH = 2,
    parameter int unsigned WB_DEPTH = 4,
    parameter int unsigned NREQ     = 3,
    localparam int unsigned CAP     = WB_WIDTH * WB_DEPTH,
    localparam int unsigned POS_W   = (CAP > 1) ? $clog2(CAP) : 1,
    localparam int unsigned CNT_W   = $clog2(WB_WIDTH + 1)
) (
    input logic                                      clk,
    input logic                                      rst,
    input logic [NREQ-1:0]                           req_vld,
    input logic [NREQ-1:0]                           grant_vld,
    input logic [NREQ*POS_W-1:0]                     grant_pos,
    input logic                                      ovf,
    input logic [WB_WIDTH-1:0]                       cmt_vld,
    input logic [WB_WIDTH-1:0]                       cmt_squash,
    input logic [CNT_W-1:0]                          rel_cnt,
    input logic [WB_WIDTH*SLOT_NDST-1:0]             sb_set_vld,
    input logic [WB_WIDTH*SLOT_NDST*SLOT_TAG_W-1:0]  sb_set_tag,
    input logic [WB_WIDTH*SLOT_NDST-1:0]             wake_vld,
    input logic [WB_WIDTH*SLOT_NDST*SLOT_TAG_W-1:0]  wake_tag
);

    // R1: queue is empty right after reset
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmt_vld == '0 && rel_cnt == '0));

    // R2: position 0 reaches head slot 0 one cycle later
    a_r2_pos0_next_head: assert property (@(posedge clk) disable iff (rst)
        (grant_vld[0] && grant_pos[POS_W-1:0] == '0) |=> cmt_vld[0]);

    // R4: overflow always leaves a valid request ungranted
    a_r4_ovf_drops: assert property (@(posedge clk) disable iff (rst)
        ovf |-> ((grant_vld & req_vld) != req_vld));

    // R9: no grant without a request
    a_r9_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        (grant_vld & ~req_vld) == '0);

    // R5: head delivery is a contiguous run from slot 0
    a_r5_prefix_run: assert property (@(posedge clk) disable iff (rst)
        ((({1'b0, cmt_vld}) + 1'b1) & {1'b0, cmt_vld}) == '0);

    // R8: release count matches delivered slots
    a_r8_release_count: assert property (@(posedge clk) disable iff (rst)
        rel_cnt == CNT_W'($countones(cmt_vld)));

    // R6: wakeup mirrors the scoreboard set, tags included
    a_r6_wake_mirror: assert property (@(posedge clk) disable iff (rst)
        wake_vld == sb_set_vld && wake_tag == sb_set_tag);

    for (genvar i = 0; i < WB_WIDTH; i++) begin : g_si
        for (genvar j = 0; j < SLOT_NDST; j++) begin : g_sj
            // R6: strobes only for delivered, unsquashed head slots
            a_r6_set_clean: assert property (@(posedge clk) disable iff (rst)
                sb_set_vld[i*SLOT_NDST+j] |-> (cmt_vld[i] && !cmt_squash[i]));
        end
    end

endmodule

bind wb_slot_alloc wbq_chk #(
    .WB_WIDTH (WB_WIDTH),
    .WB_DEPTH (WB_DEPTH),
    .NREQ     (NREQ)
) u_chk (.*);

// File: tb/tb_wb_slot_alloc.sv
`timescale 1ns/1ps
module tb_wb_slot_alloc;

    localparam int W   = 2;
    localparam int D   = 4;
    localparam int NR  = 3;
    localparam int IW  = 2;
    localparam int TW  = 6;
    localparam int ND  = 2;
    localparam int CAP = W * D;
    localparam int PW  = 3;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NR-1:0]        req_vld = '0, req_exec = '0, req_squash = '0;
    logic [NR*IW-1:0]     req_tid = '0;
    logic [NR*ND-1:0]     req_dst_vld = '0;
    logic [NR*ND*TW-1:0]  req_dst_tag = '0;
    logic [NR-1:0]        grant_vld;
    logic [NR*PW-1:0]     grant_pos;
    logic                 ovf;
    logic [W-1:0]         cmt_vld, cmt_squash;
    logic [W*IW-1:0]      cmt_tid;
    logic [CW-1:0]        rel_cnt;
    logic [W*ND-1:0]      sb_set_vld, wake_vld;
    logic [W*ND*TW-1:0]   sb_set_tag, wake_tag;

    wb_slot_alloc #(.WB_WIDTH(W), .WB_DEPTH(D), .NREQ(NR)) dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // Scoreboard: expected buffer contents, indexed by linear position
    logic           m_v [CAP];
    logic           m_s [CAP];
    logic           m_e [CAP];
    logic [IW-1:0]  m_t [CAP];
    logic [ND-1:0]  m_d [CAP];
    logic [ND*TW-1:0] m_g [CAP];

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Monitor: compare head outputs with the scoreboard's head row
    task automatic check_head();
        logic run;
        logic [W-1:0] ev, es;
        logic [W*IW-1:0] et;
        logic [W*ND-1:0] ed;
        int cnt;
        run = 1'b1; ev = '0; es = '0; et = '0; ed = '0; cnt = 0;
        for (int i = 0; i < W; i++) begin
            ev[i] = run && m_v[i];
            run   = ev[i];
            es[i] = ev[i] && m_s[i];
            if (ev[i]) et[i*IW +: IW] = m_t[i];
            cnt += int'(ev[i]);
            for (int j = 0; j < ND; j++)
                ed[i*ND+j] = ev[i] && m_e[i] && !m_s[i] && m_d[i][j];
        end
        chk(cmt_vld == ev, "R2 R5 delivered slots", 64'(cmt_vld), 64'(ev));
        chk(cmt_squash == es, "R7 squash flag", 64'(cmt_squash), 64'(es));
        chk(cmt_tid == et, "R2 thread id", 64'(cmt_tid), 64'(et));
        chk(rel_cnt == CW'(cnt), "R8 release count", 64'(rel_cnt), 64'(cnt));
        chk(sb_set_vld == ed, "R6 set strobes", 64'(sb_set_vld), 64'(ed));
        chk(wake_vld == ed, "R6 wake strobes", 64'(wake_vld), 64'(ed));
        for (int i = 0; i < W; i++)
            for (int j = 0; j < ND; j++)
                if (ed[i*ND+j]) begin
                    chk(sb_set_tag[(i*ND+j)*TW +: TW] == m_g[i][j*TW +: TW],
                        "R6 set tag", 64'(sb_set_tag[(i*ND+j)*TW +: TW]),
                        64'(m_g[i][j*TW +: TW]));
                    chk(wake_tag[(i*ND+j)*TW +: TW] == m_g[i][j*TW +: TW],
                        "R6 wake tag", 64'(wake_tag[(i*ND+j)*TW +: TW]),
                        64'(m_g[i][j*TW +: TW]));
                end
    endtask

    // Driver: one cycle of requests; called at a falling edge
    task automatic step(input logic [NR-1:0] v, input logic [NR-1:0] ex,
                        input logic [NR-1:0] sq, input logic [NR*IW-1:0] tid,
                        input logic [NR*ND-1:0] dv,
                        input logic [NR*ND*TW-1:0] tg);
        logic occ [CAP];
        logic [NR-1:0] eg;
        int   ep [NR];
        logic eo;
        check_head();
        req_vld = v; req_exec = ex; req_squash = sq; req_tid = tid;
        req_dst_vld = dv; req_dst_tag = tg;
        #1;
        for (int p = 0; p < CAP; p++) occ[p] = (p < CAP - W) ? m_v[p + W] : 1'b0;
        eg = '0; eo = 1'b0;
        for (int k = 0; k < NR; k++) begin
            ep[k] = 0;
            if (v[k]) begin
                for (int p = CAP - 1; p >= 0; p--) if (!occ[p]) begin eg[k] = 1'b1; ep[k] = p; end
                if (eg[k]) occ[ep[k]] = 1'b1; else eo = 1'b1;
            end
        end
        chk(grant_vld == eg, "R3/R9 grant set", 64'(grant_vld), 64'(eg));
        chk(ovf == eo, "R4 overflow", 64'(ovf), 64'(eo));
        for (int k = 0; k < NR; k++)
            if (eg[k] && grant_vld[k])
                chk(grant_pos[k*PW +: PW] == PW'(ep[k]), "R3/R10 grant position",
                    64'(grant_pos[k*PW +: PW]), 64'(ep[k]));
        // advance scoreboard
        for (int p = 0; p < CAP; p++) begin
            if (p < CAP - W) begin
                m_v[p] = m_v[p+W]; m_s[p] = m_s[p+W]; m_e[p] = m_e[p+W];
                m_t[p] = m_t[p+W]; m_d[p] = m_d[p+W]; m_g[p] = m_g[p+W];
            end else begin
                m_v[p] = 0; m_s[p] = 0; m_e[p] = 0; m_t[p] = '0; m_d[p] = '0; m_g[p] = '0;
            end
        end
        for (int k = 0; k < NR; k++)
            if (eg[k]) begin
                m_v[ep[k]] = 1'b1; m_s[ep[k]] = sq[k]; m_e[ep[k]] = ex[k];
                m_t[ep[k]] = tid[k*IW +: IW]; m_d[ep[k]] = dv[k*ND +: ND];
                m_g[ep[k]] = tg[k*ND*TW +: ND*TW];
            end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, '0, '0, '0, '0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        for (int p = 0; p < CAP; p++) begin
            m_v[p] = 0; m_s[p] = 0; m_e[p] = 0; m_t[p] = '0; m_d[p] = '0; m_g[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cmt_vld == '0, "R1 no delivery after reset", 64'(cmt_vld), 0);
        chk(rel_cnt == '0, "R1 release zero after reset", 64'(rel_cnt), 0);
        chk(sb_set_vld == '0, "R1 no strobes after reset", 64'(sb_set_vld), 0);
        chk(ovf == 1'b0, "R1 no overflow after reset", 64'(ovf), 0);
        @(negedge clk);
        // R2 R6: one clean request with two destinations
        step(3'b001, 3'b001, 3'b000, 6'h01, 6'b000011, {24'h0, 6'h15, 6'h2a});
        chk(cmt_vld == 2'b01, "R2 entry at head next cycle", 64'(cmt_vld), 1);
        idle(1);
        // R3: two requests in one cycle take positions 0 and 1
        step(3'b011, 3'b011, 3'b000, 6'h0e, 6'b001101, {12'h0, 12'h3c5, 12'h0a7});
        idle(1);
        // R7: squashed and unexecuted entries still delivered, no strobes
        step(3'b110, 3'b010, 3'b100, 6'h2d, 6'b111111, 36'hfedcba987);
        idle(1);
        // R9: idle request with busy fields is ignored
        step(3'b000, 3'b111, 3'b000, 6'h3f, 6'b111111, 36'hfffffffff);
        chk(cmt_vld == 2'b00, "R9 nothing delivered for idle request", 64'(cmt_vld), 0);
        // R4 R10: three per cycle against a drain of two fills the buffer
        for (int c = 0; c < 9; c++)
            step(3'b111, 3'b101, 3'b010, 6'(c * 7), 6'b011011, 36'(c * 64'h123457));
        idle(5);
        // patterned traffic
        lf = 16'hace1;
        for (int c = 0; c < 300; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[2:0], lf[5:3], lf[8:6], lf[14:9], lf[15:10],
                 {lf, lf[11:0], lf[15:8]});
        end
        idle(5);
        step(3'b100, 3'b100, 3'b000, 6'h20, 6'b100000, {6'h11, 30'h0});
        idle(2);
        finish_run();
    end

endmodule